// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Interrupts

This block receives asynchronous serial characters on one line, `rxd`. A tick input, `tick16`, pulses sixteen times per bit and sets the bit rate. Each character has a low start bit, then 8 or 9 data bits sent least significant bit first, then a stop bit. Each bit is sampled three times near its middle and the majority value is kept. The finished character goes into a data holding register. Four status flags record a held character, an idle line, an overrun and noise. Each flag is combined with its own enable into one of two interrupt requests: one for received data and one for errors.

A standby mode lets the receiver skip traffic that is not meant for it. While standby is set, finished characters and idle detection do not touch the data or the flags. A long enough stretch of idle line clears standby by itself. A host clears the flags in two steps: a status-read strobe records which flags are set, and a later data-read strobe clears exactly those flags.

Top module: `uart_rx_status`

## Requirements
- R1: A character is detected from a low level seen on a tick while the receiver is waiting. It is taken as one start bit, 8 data bits (9 when `nineBit`=1) least significant bit first, and one stop bit, each 16 ticks long. The data bits appear right-aligned on `rxData`, with bit 8 equal to 0 in 8-bit mode.
- R2: Each bit takes the majority of the samples at ticks 8, 9 and 10 of the bit, where the tick that detects the start bit is tick 1. A value on the line at any other tick of a bit has no effect on the data or on `noiseFlag`.
- R3: `noiseFlag` sets when a character completes if the three samples of any of its bits disagreed. This covers the start, data and stop bits, and break characters (all bits low, including the stop bit).
- R4: When a character completes while `fullFlag`=0, it is written to `rxData` and `fullFlag` sets. A break character is stored as 0.
- R5: When a character completes while `fullFlag`=1, `ovrFlag` sets and `rxData` keeps the older character.
- R6: `idleFlag` sets once the idle count reaches 160 ticks (8-bit mode) or 176 ticks (9-bit mode) of consecutive high samples. It sets only if a character has started since the last time it was set. A low sample restarts the count.
- R7: With `idleAfterStop`=1, high samples count toward idle only while the receiver waits for a start bit. With `idleAfterStop`=0, they also count during the data and stop bits.
- R8: A `readStatus` pulse records the flags that are set. A later `readData` pulse clears exactly those flags. A `readData` with no `readStatus` before it clears nothing.
- R9: `rxIrq` = (`fullFlag` and `rxIntEn`) or (`idleFlag` and `idleIntEn`).
- R10: `errIrq` = (`ovrFlag` and `ovrIntEn`) or (`noiseFlag` and `noiseIntEn`).
- R11: A `standbySet` pulse sets `standby`. While `standby`=1, finished characters change neither `rxData` nor any flag, and reaching the idle count does not set `idleFlag`. `standby` clears one clock after the idle count has been reached.
- R12: Setting standby does not restart the idle count. If the line has already been idle long enough, `standby` clears on the clock after it was set.
- R13: Reset clears `rxData`, every flag, `standby` and both interrupt requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial input, high when idle |
| nineBit | input | 1 | 1 selects 9 data bits |
| idleAfterStop | input | 1 | 1: idle count starts after the stop bit; 0: after the start bit |
| standbySet | input | 1 | Pulse that enters standby |
| readStatus | input | 1 | Status-read strobe |
| readData | input | 1 | Data-read strobe |
| rxIntEn | input | 1 | Enables the full flag onto rxIrq |
| idleIntEn | input | 1 | Enables the idle flag onto rxIrq |
| ovrIntEn | input | 1 | Enables the overrun flag onto errIrq |
| noiseIntEn | input | 1 | Enables the noise flag onto errIrq |
| rxData | output | 9 | Received character |
| fullFlag | output | 1 | Character waiting |
| idleFlag | output | 1 | Idle line seen |
| ovrFlag | output | 1 | Character lost to overrun |
| noiseFlag | output | 1 | Sample disagreement seen |
| standby | output | 1 | Receiver in standby |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Error interrupt request |

## Verification
Glitches are placed inside the three-sample window and outside it. A design that samples at the wrong ticks would either corrupt data or raise noise on a harmless glitch. The idle threshold is probed one tick before and at the exact tick, in both count-start modes and both data widths. An off-by-one count, or a count that runs through the start bit, moves the flag by a tick. Characters are sent back to back without reads, so a design that overwrites on overrun shows the newer byte. Standby is entered both on a busy line and on a line that is already idle. A design that restarts the count on standby would fail to wake at once.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic bitValid;   // a data bit finished, value in bitVal
    logic bitVal;
    logic charDone;   // stop bit finished, character complete
    logic charNoise;  // some sample disagreement in this character
    logic idleEvent;  // idle count reaches threshold this tick
    logic idleLevel;  // idle count is at threshold
  } urxStrobe_t;
endpackage

// File: rtl/urx_ctrl.sv
module urx_ctrl
  import urx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       nineBit,
  input  logic       idleAfterStop,
  output urxStrobe_t strb
);
  localparam int PH_W     = $clog2(OVERSAMPLE) + 1;
  localparam int MID      = OVERSAMPLE / 2;
  localparam int IDLE_MAX = 11 * OVERSAMPLE;
  localparam int IC_W     = $clog2(IDLE_MAX + 1);

  rxState_t        state;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] phaseNext;
  logic [2:0]      samp;
  logic [3:0]      bitIdx;
  logic            frameNoise;
  logic [IC_W-1:0] idleCnt;
  logic [IC_W-1:0] idleThr;
  logic            armed;
  logic            maj;
  logic            noisy;
  logic            bitEnd;
  logic            countEn;
  logic [3:0]      lastBit;

  always_comb begin
    phaseNext = phase + 1'b1;
    maj       = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
    noisy     = !((samp[0] == samp[1]) && (samp[1] == samp[2]));
    idleThr   = nineBit ? IC_W'(11 * OVERSAMPLE) : IC_W'(10 * OVERSAMPLE);
    countEn   = idleAfterStop ? (state == ST_IDLE) : (state != ST_START);
    lastBit   = nineBit ? 4'd8 : 4'd7;
    bitEnd    = tick16 && (state != ST_IDLE) && (phaseNext == PH_W'(OVERSAMPLE));

    strb.bitValid  = bitEnd && (state == ST_DATA);
    strb.bitVal    = maj;
    strb.charDone  = bitEnd && (state == ST_STOP);
    strb.charNoise = frameNoise | noisy;
    strb.idleEvent = tick16 && rxd && countEn && armed && (idleCnt == idleThr - 1'b1);
    strb.idleLevel = (idleCnt >= idleThr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= '0;
      samp       <= '0;
      bitIdx     <= '0;
      frameNoise <= 1'b0;
      idleCnt    <= '0;
      armed      <= 1'b0;
    end else if (tick16) begin
      if (!rxd)
        idleCnt <= '0;
      else if (countEn && (idleCnt < idleThr))
        idleCnt <= idleCnt + 1'b1;
      if (strb.idleEvent)
        armed <= 1'b0;

      if (state == ST_IDLE) begin
        if (!rxd) begin
          state <= ST_START;
          phase <= PH_W'(1);
        end
      end else begin
        phase <= bitEnd ? '0 : phaseNext;
        if (phaseNext == PH_W'(MID))     samp[0] <= rxd;
        if (phaseNext == PH_W'(MID + 1)) samp[1] <= rxd;
        if (phaseNext == PH_W'(MID + 2)) samp[2] <= rxd;
        if (bitEnd) begin
          unique case (state)
            ST_START: begin
              if (maj) begin
                state <= ST_IDLE;          // false start
              end else begin
                state      <= ST_DATA;
                bitIdx     <= '0;
                frameNoise <= noisy;
                armed      <= 1'b1;
              end
            end
            ST_DATA: begin
              frameNoise <= frameNoise | noisy;
              if (bitIdx == lastBit) state <= ST_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end
            default: state <= ST_IDLE;     // stop bit done
          endcase
        end
      end
    end
  end

  // R6: reaching the threshold leaves the count at threshold
  a_r6_event_level: assert property (@(posedge clk) disable iff (!rstN)
    strb.idleEvent |=> strb.idleLevel);
endmodule

// File: rtl/urx_datapath.sv
module urx_datapath
  import urx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  urxStrobe_t strb,
  input  logic       nineBit,
  input  logic       standbySet,
  input  logic       readStatus,
  input  logic       readData,
  output logic [8:0] rxData,
  output logic       fullFlag,
  output logic       idleFlag,
  output logic       ovrFlag,
  output logic       noiseFlag,
  output logic       standby
);
  logic [8:0] shiftReg;
  logic [8:0] newChar;
  logic [3:0] snap;  // {noise, ovr, idle, full} seen at status read

  assign newChar = nineBit ? shiftReg : {1'b0, shiftReg[8:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxData    <= '0;
      fullFlag  <= 1'b0;
      idleFlag  <= 1'b0;
      ovrFlag   <= 1'b0;
      noiseFlag <= 1'b0;
      standby   <= 1'b0;
      snap      <= '0;
    end else begin
      if (strb.bitValid)
        shiftReg <= {strb.bitVal, shiftReg[8:1]};

      // clearing first, so a same-cycle set wins
      if (readData) begin
        if (snap[0]) fullFlag  <= 1'b0;
        if (snap[1]) idleFlag  <= 1'b0;
        if (snap[2]) ovrFlag   <= 1'b0;
        if (snap[3]) noiseFlag <= 1'b0;
        snap <= '0;
      end
      if (readStatus)
        snap <= {noiseFlag, ovrFlag, idleFlag, fullFlag};

      if (strb.charDone && !standby) begin
        if (fullFlag) begin
          ovrFlag <= 1'b1;
        end else begin
          rxData   <= newChar;
          fullFlag <= 1'b1;
        end
        if (strb.charNoise) noiseFlag <= 1'b1;
      end
      if (strb.idleEvent && !standby)
        idleFlag <= 1'b1;

      if (standbySet)          standby <= 1'b1;
      else if (strb.idleLevel) standby <= 1'b0;
    end
  end

  a_r4_full_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (strb.charDone && !standby && !fullFlag) |=> (fullFlag && rxData == $past(newChar)));
  a_r5_keep_old: assert property (@(posedge clk) disable iff (!rstN)
    (strb.charDone && !standby && fullFlag) |=> (ovrFlag && $stable(rxData)));
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strb.charDone && standby) |=> $stable(rxData));
  a_r11_wake: assert property (@(posedge clk) disable iff (!rstN)
    (standby && strb.idleLevel && !standbySet) |=> !standby);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import urx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       nineBit,
  input  logic       idleAfterStop,
  input  logic       standbySet,
  input  logic       readStatus,
  input  logic       readData,
  input  logic       rxIntEn,
  input  logic       idleIntEn,
  input  logic       ovrIntEn,
  input  logic       noiseIntEn,
  output logic [8:0] rxData,
  output logic       fullFlag,
  output logic       idleFlag,
  output logic       ovrFlag,
  output logic       noiseFlag,
  output logic       standby,
  output logic       rxIrq,
  output logic       errIrq
);
  urxStrobe_t strb;

  urx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxd(rxd),
    .nineBit(nineBit), .idleAfterStop(idleAfterStop), .strb(strb)
  );

  urx_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .nineBit(nineBit),
    .standbySet(standbySet), .readStatus(readStatus), .readData(readData),
    .rxData(rxData), .fullFlag(fullFlag), .idleFlag(idleFlag),
    .ovrFlag(ovrFlag), .noiseFlag(noiseFlag), .standby(standby)
  );

  assign rxIrq  = (fullFlag & rxIntEn) | (idleFlag & idleIntEn);
  assign errIrq = (ovrFlag & ovrIntEn) | (noiseFlag & noiseIntEn);
endmodule

// File: tb/uart_rx_status_tb_top.sv
`timescale 1ns/1ps
module uart_rx_status_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0, rxd = 1'b1, nineBit = 1'b0, idleAfterStop = 1'b1;
  logic standbySet = 1'b0, readStatus = 1'b0, readData = 1'b0;
  logic rxIntEn = 1'b0, idleIntEn = 1'b0, ovrIntEn = 1'b0, noiseIntEn = 1'b0;
  logic [8:0] rxData;
  logic fullFlag, idleFlag, ovrFlag, noiseFlag, standby, rxIrq, errIrq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [8:0] mData = '0;
  logic mFull = 0, mIdle = 0, mOvr = 0, mNoise = 0;

  always #2.5 clk = ~clk;

  uart_rx_status dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expRx();
    return (mFull & rxIntEn) | (mIdle & idleIntEn);
  endfunction
  function automatic logic expErr();
    return (mOvr & ovrIntEn) | (mNoise & noiseIntEn);
  endfunction

  task automatic oneTick(input logic v);
    @(negedge clk); rxd = v; tick16 = 1'b1;
    @(negedge clk); tick16 = 1'b0;
  endtask

  task automatic sendBit(input logic v, input int glitchAt);
    for (int k = 1; k <= 16; k++) oneTick((k == glitchAt) ? ~v : v);
  endtask

  // glitchBit: 0 start, 1..n data, n+1 stop, -1 none
  task automatic sendFrame(input logic [8:0] d, input logic stopV,
                           input int glitchBit, input int glitchTick);
    int n = nineBit ? 9 : 8;
    sendBit(1'b0, (glitchBit == 0) ? glitchTick : 0);
    for (int b = 0; b < n; b++) sendBit(d[b], (glitchBit == b + 1) ? glitchTick : 0);
    sendBit(stopV, (glitchBit == n + 1) ? glitchTick : 0);
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) oneTick(1'b1);
  endtask

  task automatic modelChar(input logic [8:0] d, input logic noisy);
    if (mFull) mOvr = 1; else begin mData = d; mFull = 1; end
    if (noisy) mNoise = 1;
  endtask

  task automatic pulseStatus(); @(negedge clk); readStatus = 1; @(negedge clk); readStatus = 0; endtask
  task automatic pulseData();   @(negedge clk); readData = 1;   @(negedge clk); readData = 0;   endtask
  task automatic pulseStandby(); @(negedge clk); standbySet = 1; @(negedge clk); standbySet = 0; endtask

  task automatic readClear();
    pulseStatus(); pulseData();
    mFull = 0; mIdle = 0; mOvr = 0; mNoise = 0;
  endtask

  task automatic checkAll(string req);
    check({req, " data"},  rxData,    mData);
    check({req, " full"},  fullFlag,  mFull);
    check({req, " idle"},  idleFlag,  mIdle);
    check({req, " ovr"},   ovrFlag,   mOvr);
    check({req, " noise"}, noiseFlag, mNoise);
    check("R9 rxIrq",      rxIrq,     expRx());
    check("R10 errIrq",    errIrq,    expErr());
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4099));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    checkAll("R13 reset");
    check("R13 standby", standby, 0);

    rxIntEn = 1; idleIntEn = 1; ovrIntEn = 1; noiseIntEn = 1;
    idleTicks(200);
    check("R6 no idle before any frame", idleFlag, 0);

    // R1 R4 clean frame
    sendFrame(9'h0A5, 1, -1, 0); modelChar(9'h0A5, 0);
    checkAll("R1 R4 clean");
    pulseData();
    check("R8 data read alone keeps full", fullFlag, 1);
    readClear(); checkAll("R8 cleared");

    // R2 glitch outside window
    sendFrame(9'h03C, 1, 3, 3); modelChar(9'h03C, 0);
    checkAll("R2 glitch off window");
    readClear();
    sendFrame(9'h05A, 1, 5, 9); modelChar(9'h05A, 1);
    checkAll("R2 R3 glitch data bit");
    readClear();
    sendFrame(9'h0C3, 1, 0, 10); modelChar(9'h0C3, 1);
    checkAll("R3 glitch start bit");
    readClear();
    sendFrame(9'h081, 1, 9, 8); modelChar(9'h081, 1);
    checkAll("R3 glitch stop bit");

    // R5 overrun
    sendFrame(9'h011, 1, -1, 0); modelChar(9'h011, 0);
    checkAll("R5 overrun");
    ovrIntEn = 0; noiseIntEn = 0;
    @(negedge clk);
    check("R10 masked errIrq", errIrq, 0);
    ovrIntEn = 1; noiseIntEn = 1;
    readClear();

    // R6 R7 idle after stop, 8-bit
    sendFrame(9'h0F0, 1, -1, 0); modelChar(9'h0F0, 0);
    readClear();
    idleTicks(159); check("R6 idle one tick early", idleFlag, 0);
    idleTicks(1);   mIdle = 1; checkAll("R6 idle at threshold");
    readClear();

    // R7 idle after start bit
    idleAfterStop = 0;
    sendFrame(9'h0FF, 1, -1, 0); modelChar(9'h0FF, 0);
    readClear();
    idleTicks(15); check("R7 after-start early", idleFlag, 0);
    idleTicks(1);  check("R7 after-start set", idleFlag, 1);
    readClear();
    sendFrame(9'h07F, 1, -1, 0); modelChar(9'h07F, 0);
    readClear();
    idleTicks(143); check("R7 low msb early", idleFlag, 0);
    idleTicks(1);   check("R7 low msb set", idleFlag, 1);
    readClear();
    idleAfterStop = 1;

    // R1 R6 nine-bit
    nineBit = 1;
    sendFrame(9'h1A5, 1, -1, 0); modelChar(9'h1A5, 0);
    checkAll("R1 nine-bit data");
    readClear();
    idleTicks(175); check("R6 nine-bit early", idleFlag, 0);
    idleTicks(1);   check("R6 nine-bit set", idleFlag, 1);
    readClear();
    nineBit = 0;

    // R3 R4 break characters
    sendFrame(9'h000, 0, -1, 0); modelChar(9'h000, 0);
    checkAll("R4 break stored");
    readClear();
    sendFrame(9'h000, 0, 9, 9); modelChar(9'h000, 1);
    checkAll("R3 break noise");
    readClear();

    // R11 standby
    sendFrame(9'h021, 1, -1, 0); modelChar(9'h021, 0);
    readClear();
    pulseStandby();
    @(negedge clk);
    check("R11 standby set", standby, 1);
    sendFrame(9'h042, 1, 6, 9);
    checkAll("R11 frame ignored in standby");
    idleTicks(159);
    check("R11 still standby", standby, 1);
    idleTicks(1);
    @(negedge clk);
    check("R11 woke", standby, 0);
    check("R11 idle suppressed", idleFlag, 0);
    sendFrame(9'h063, 1, -1, 0); modelChar(9'h063, 0);
    checkAll("R11 after wake");
    readClear();

    // R12 immediate wake on idle line
    idleTicks(200);
    mIdle = 1; readClear();
    pulseStandby();
    @(negedge clk);
    check("R12 immediate wake", standby, 0);

    // random frames, R1 R2 R3 R4 R5 R8 R9 R10
    for (int it = 0; it < 150; it++) begin
      logic [8:0] d = {1'b0, 8'($urandom)};
      int g = $urandom % 4;
      int gb = -1, gt = 0;
      logic noisy = 0;
      if (g == 0) begin gb = $urandom % 10; gt = 8 + ($urandom % 3); noisy = 1; end
      else if (g == 1) begin gb = $urandom % 10; gt = 3 + ($urandom % 4); end
      rxIntEn = 1'($urandom); idleIntEn = 1'($urandom);
      ovrIntEn = 1'($urandom); noiseIntEn = 1'($urandom);
      sendFrame(d, 1, gb, gt);
      modelChar(d, noisy);
      idleTicks(($urandom % 4) * 16);
      checkAll("R1 R5 random");
      if (($urandom % 3) == 0) begin
        readClear();
        checkAll("R8 random clear");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule